// File: doc/BRIEF.md
# Dual-I/O Serial Command Responder

This block is the slave-side command front end of a serial memory that talks over two data pins at once. A host selects it by pulling chip select low, then clocks an 8-bit command in two bits per serial clock on a pair of data pins. The block decodes the command. It can return a 24-bit identity, read or write two volatile 8-bit configuration registers, or apply a two-step software reset that returns both registers to their built-in defaults. A busy input from an external program/erase engine blocks the identity read while that engine is working.

All pins are oversampled in the block's own clock domain. Chip select, serial clock and data in each pass through a small synchronizer. Rising and falling serial-clock edges are then found as one-cycle events: data is taken in on rising edges and changed on falling edges. The bidirectional pair is exposed as separate input, output and output-enable signals so that the pad ring can build the tri-state buffer. The two register values are also driven out as plain control outputs for the rest of the chip. The serial side has no back-pressure. The host owns the serial clock, and every byte is taken or given at the pace the host sets, so there is no valid/ready pair at the edge.

Top module: `dio_cmd_responder`

## Requirements
- R1: A transaction begins when chip select goes low. The command byte is taken in over four serial-clock rising edges, two bits per edge, most significant pair first. Within each pair, data pin 1 (bit 1 of `dq_i`) carries the higher bit.
- R2: The identity command (parameter `ID_OP`, default AFh) returns the manufacturer byte `MFR` followed by the 16-bit `DEV` code. The 24 bits go out as 12 pairs, most significant first, with data pin 1 carrying the higher bit of each pair. After the twelfth pair the output enables drop.
- R3: Output data and output enables change only after a serial-clock falling edge. Both enables stay low while the command byte is being received.
- R4: While `busy` is high, a completed identity command is not acted on. The output enables stay low until chip select rises.
- R5: Command 81h writes `cfg_vol` and 61h writes `cfg_enh`. Each complete data byte that follows the command is committed, so the last complete byte wins. A byte cut short by chip select rising leaves the register unchanged.
- R6: Command 85h reads `cfg_vol` and 65h reads `cfg_enh`. The value is sent most significant pair first and repeats byte after byte while the clock continues.
- R7: After reset, `cfg_vol` = `CFG_DEF` and `cfg_enh` = `ENH_DEF`. A 99h command whose previous completed transaction was 66h restores both defaults.
- R8: A 99h command has no effect on the registers when the previous completed transaction was not 66h, including when another complete command came between 66h and 99h.
- R9: Unrecognised commands are ignored. The enables stay low until chip select rises, and both registers keep their values.
- R10: Raising chip select at any point, including part-way through an output, ends the transaction. The enables are low within two clock cycles of the synchronized rise, and the next selection decodes a fresh command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock used to oversample the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock from the host, idle low |
| dq_i | input | 2 | Data pin pair as seen at the pads; bit 1 is the higher bit of each pair |
| busy | input | 1 | High while the external program/erase engine is working |
| dq_o | output | 2 | Data driven toward the pads |
| dq_oe | output | 2 | Output enables for the pad pair |
| cfg_vol | output | 8 | Volatile configuration register |
| cfg_enh | output | 8 | Volatile enhanced configuration register |

## Verification
A serial-clock edge reaches the edge detector `SYNC_STAGES` + 1 clock cycles after it appears at the pin. One more register stage follows before a data pair appears on `dq_o` or a written byte appears on the register outputs, so every result is due `SYNC_STAGES` + 2 cycles after its edge. The bench holds each serial-clock phase for six clock cycles. It samples `dq_o` and `dq_oe` on the last clock before each rising edge, which is after the preceding falling edge's output has settled. Register outputs and reset effects are read only after chip select has been high for several phases. Values sweep over most of the 8-bit range for both registers, and the identity pairs are computed from the parameters by shifting.

// File: rtl/dio_resp_pkg.sv
package dio_resp_pkg;
  typedef enum logic [2:0] {
    ST_OPC,
    ST_WR_CFG,
    ST_WR_ENH,
    ST_OUT,
    ST_IGN
  } ctl_state_t;

  localparam logic [7:0] OP_RST_EN = 8'h66;
  localparam logic [7:0] OP_RST_GO = 8'h99;
  localparam logic [7:0] OP_WR_CFG = 8'h81;
  localparam logic [7:0] OP_RD_CFG = 8'h85;
  localparam logic [7:0] OP_WR_ENH = 8'h61;
  localparam logic [7:0] OP_RD_ENH = 8'h65;
endpackage

// File: rtl/dio_pin_sync.sv
module dio_pin_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[i] <= INIT;
      else if (i == 0) stg[i] <= d;
      else stg[i] <= stg[(i == 0) ? 0 : i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/dio_rx_shift.sv
module dio_rx_shift #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              rise,
  input  logic [1:0]        dq,
  output logic              byte_vld,
  output logic [BYTE_W-1:0] byte_q
);
  localparam int PAIRS = BYTE_W / 2;
  localparam int CW = (PAIRS > 1) ? $clog2(PAIRS) : 1;

  logic [CW-1:0]     cnt;
  logic [BYTE_W-1:0] sh;
  logic [BYTE_W-1:0] nxt;

  assign nxt = {sh[BYTE_W-3:0], dq};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      sh       <= '0;
      byte_vld <= 1'b0;
      byte_q   <= '0;
    end else begin
      byte_vld <= 1'b0;
      if (clr) begin
        cnt <= '0;
      end else if (rise) begin
        sh <= nxt;
        if (cnt == CW'(PAIRS-1)) begin
          cnt      <= '0;
          byte_vld <= 1'b1;
          byte_q   <= nxt;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  // R1: a completed byte only follows an accepted rising edge
  a_r1_byte_after_rise: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld |-> ($past(rise) && !$past(clr)));
endmodule

// File: rtl/dio_tx_shift.sv
module dio_tx_shift #(
  parameter int DW = 24,
  parameter int BYTE_W = 8,
  parameter int LW = $clog2(DW/2 + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              fall,
  input  logic              load,
  input  logic [DW-1:0]     load_data,
  input  logic [LW-1:0]     load_pairs,
  input  logic              rpt,
  input  logic [BYTE_W-1:0] rpt_byte,
  output logic [1:0]        dq_o,
  output logic              oe_o
);
  logic [DW-1:0]     sh;
  logic [LW-1:0]     left;
  logic              active;
  logic              rep;
  logic [BYTE_W-1:0] rbyte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh     <= '0;
      left   <= '0;
      active <= 1'b0;
      rep    <= 1'b0;
      rbyte  <= '0;
      dq_o   <= 2'b00;
      oe_o   <= 1'b0;
    end else if (clr) begin
      active <= 1'b0;
      left   <= '0;
      oe_o   <= 1'b0;
    end else if (load) begin
      sh     <= load_data;
      left   <= load_pairs;
      rep    <= rpt;
      rbyte  <= rpt_byte;
      active <= 1'b1;
    end else if (fall && active) begin
      if (left != '0) begin
        dq_o <= sh[DW-1:DW-2];
        sh   <= sh << 2;
        left <= left - 1'b1;
        oe_o <= 1'b1;
      end else if (rep) begin
        dq_o <= rbyte[BYTE_W-1:BYTE_W-2];
        sh   <= {rbyte[BYTE_W-3:0], {(DW-BYTE_W+2){1'b0}}};
        left <= LW'(BYTE_W/2 - 1);
        oe_o <= 1'b1;
      end else begin
        active <= 1'b0;
        oe_o   <= 1'b0;
      end
    end
  end

  // R3: the pads are only turned on by a falling serial-clock edge
  a_r3_oe_rises_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe_o) |-> $past(fall));
  // R3: output data only moves on a falling serial-clock edge
  a_r3_data_moves_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dq_o) |-> $past(fall));
endmodule

// File: rtl/dio_cmd_responder.sv
module dio_cmd_responder
  import dio_resp_pkg::*;
#(
  parameter logic [7:0]  ID_OP       = 8'hAF,
  parameter logic [7:0]  MFR         = 8'h3C,
  parameter logic [15:0] DEV         = 16'h71E4,
  parameter logic [7:0]  CFG_DEF     = 8'hFB,
  parameter logic [7:0]  ENH_DEF     = 8'hDF,
  parameter int          SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       sclk,
  input  logic [1:0] dq_i,
  input  logic       busy,
  output logic [1:0] dq_o,
  output logic [1:0] dq_oe,
  output logic [7:0] cfg_vol,
  output logic [7:0] cfg_enh
);
  localparam int BYTE_W = 8;
  localparam int ID_W   = 8 + 16;
  localparam int TX_LW  = $clog2(ID_W/2 + 1);

  logic       s_cs, s_sclk;
  logic [1:0] s_dq;
  logic       sclk_d, cs_d;
  logic       rise, fall, cs_up;

  dio_pin_sync #(.W(4), .STAGES(SYNC_STAGES), .INIT(4'b1000)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({cs_n, sclk, dq_i}), .q({s_cs, s_sclk, s_dq})
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d <= 1'b0;
      cs_d   <= 1'b1;
    end else begin
      sclk_d <= s_sclk;
      cs_d   <= s_cs;
    end
  end

  assign rise  = s_sclk & ~sclk_d & ~s_cs;
  assign fall  = ~s_sclk & sclk_d & ~s_cs;
  assign cs_up = s_cs & ~cs_d;

  logic              byte_vld;
  logic [BYTE_W-1:0] rx_byte;

  dio_rx_shift #(.BYTE_W(BYTE_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .clr(s_cs), .rise(rise), .dq(s_dq),
    .byte_vld(byte_vld), .byte_q(rx_byte)
  );

  ctl_state_t        state;
  logic              opc_seen;
  logic [7:0]        opc_q;
  logic              arm;
  logic              tx_load;
  logic [ID_W-1:0]   tx_data;
  logic [TX_LW-1:0]  tx_pairs;
  logic              tx_rpt;
  logic [BYTE_W-1:0] tx_rbyte;
  logic              op_done;

  assign op_done = byte_vld && !s_cs && (state == ST_OPC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_OPC;
      opc_seen <= 1'b0;
      opc_q    <= '0;
      arm      <= 1'b0;
      cfg_vol  <= CFG_DEF;
      cfg_enh  <= ENH_DEF;
      tx_load  <= 1'b0;
      tx_data  <= '0;
      tx_pairs <= '0;
      tx_rpt   <= 1'b0;
      tx_rbyte <= '0;
    end else begin
      tx_load <= 1'b0;
      if (s_cs) begin
        state    <= ST_OPC;
        opc_seen <= 1'b0;
        if (cs_up && opc_seen) arm <= (opc_q == OP_RST_EN);
      end else if (byte_vld) begin
        case (state)
          ST_OPC: begin
            opc_q    <= rx_byte;
            opc_seen <= 1'b1;
            state    <= ST_IGN;
            if (rx_byte == ID_OP) begin
              if (!busy) begin
                tx_load  <= 1'b1;
                tx_data  <= {MFR, DEV};
                tx_pairs <= TX_LW'(ID_W/2);
                tx_rpt   <= 1'b0;
                state    <= ST_OUT;
              end
            end else if (rx_byte == OP_RST_GO) begin
              if (arm) begin
                cfg_vol <= CFG_DEF;
                cfg_enh <= ENH_DEF;
              end
            end else if (rx_byte == OP_WR_CFG) begin
              state <= ST_WR_CFG;
            end else if (rx_byte == OP_WR_ENH) begin
              state <= ST_WR_ENH;
            end else if (rx_byte == OP_RD_CFG || rx_byte == OP_RD_ENH) begin
              tx_load  <= 1'b1;
              tx_rbyte <= (rx_byte == OP_RD_CFG) ? cfg_vol : cfg_enh;
              tx_data  <= {(rx_byte == OP_RD_CFG) ? cfg_vol : cfg_enh,
                           {(ID_W-BYTE_W){1'b0}}};
              tx_pairs <= TX_LW'(BYTE_W/2);
              tx_rpt   <= 1'b1;
              state    <= ST_OUT;
            end
          end
          ST_WR_CFG: cfg_vol <= rx_byte;
          ST_WR_ENH: cfg_enh <= rx_byte;
          default: ;
        endcase
      end
    end
  end

  logic tx_oe;

  dio_tx_shift #(.DW(ID_W), .BYTE_W(BYTE_W), .LW(TX_LW)) u_tx (
    .clk(clk), .rst_n(rst_n), .clr(s_cs), .fall(fall), .load(tx_load),
    .load_data(tx_data), .load_pairs(tx_pairs), .rpt(tx_rpt),
    .rpt_byte(tx_rbyte), .dq_o(dq_o), .oe_o(tx_oe)
  );

  assign dq_oe = {tx_oe, tx_oe};

  // R4: an identity command seen while busy leads nowhere
  a_r4_busy_blocks_id: assert property (@(posedge clk) disable iff (!rst_n)
    (op_done && rx_byte == ID_OP && busy) |=> (state == ST_IGN && !tx_load));
  // R5: register contents move only right after a completed byte
  a_r5_cfg_moves_on_byte: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_vol) |-> $past(byte_vld));
  a_r5_enh_moves_on_byte: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_enh) |-> $past(byte_vld));
  // R7: armed reset restores both defaults
  a_r7_armed_reset: assert property (@(posedge clk) disable iff (!rst_n)
    (op_done && rx_byte == OP_RST_GO && arm) |=> (cfg_vol == CFG_DEF && cfg_enh == ENH_DEF));
  // R8: unarmed reset leaves both registers alone
  a_r8_unarmed_reset: assert property (@(posedge clk) disable iff (!rst_n)
    (op_done && rx_byte == OP_RST_GO && !arm) |=> ($stable(cfg_vol) && $stable(cfg_enh)));
  // R10: deselection releases the pads on the following cycle
  a_r10_release_on_cs: assert property (@(posedge clk) disable iff (!rst_n)
    cs_up |=> (dq_oe == 2'b00));
endmodule

// File: tb/dio_cmd_responder_bench.sv
module dio_cmd_responder_bench;
  localparam logic [7:0]  ID_OP   = 8'hAF;
  localparam logic [7:0]  MFR     = 8'h3C;
  localparam logic [15:0] DEV     = 16'h71E4;
  localparam logic [7:0]  CFG_DEF = 8'hFB;
  localparam logic [7:0]  ENH_DEF = 8'hDF;
  localparam int H = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1;
  logic sclk = 1'b0;
  logic [1:0] dq_i = 2'b00;
  logic busy = 1'b0;
  logic [1:0] dq_o, dq_oe;
  logic [7:0] cfg_vol, cfg_enh;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  dio_cmd_responder #(.ID_OP(ID_OP), .MFR(MFR), .DEV(DEV), .CFG_DEF(CFG_DEF),
                      .ENH_DEF(ENH_DEF), .SYNC_STAGES(2)) u_dio_cmd_responder (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .dq_i(dq_i), .busy(busy),
    .dq_o(dq_o), .dq_oe(dq_oe), .cfg_vol(cfg_vol), .cfg_enh(cfg_enh)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic pulse(input logic [1:0] p, output logic [1:0] got, output logic oe);
    dq_i = p;
    repeat (H) @(negedge clk);
    got = dq_o;
    oe  = dq_oe[0] | dq_oe[1];
    sclk = 1'b1;
    repeat (H) @(negedge clk);
    sclk = 1'b0;
  endtask

  task automatic begin_x();
    cs_n = 1'b0;
    repeat (H) @(negedge clk);
  endtask

  task automatic end_x();
    repeat (H) @(negedge clk);
    cs_n = 1'b1;
    repeat (3*H) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] b, output logic any_oe);
    logic [1:0] g;
    logic o;
    any_oe = 1'b0;
    for (int i = 3; i >= 0; i--) begin
      pulse(b[2*i +: 2], g, o);
      any_oe |= o;
    end
  endtask

  task automatic read_byte(output logic [7:0] v, output logic all_oe);
    logic [1:0] g;
    logic o;
    all_oe = 1'b1;
    v = '0;
    for (int i = 0; i < 4; i++) begin
      pulse(2'b00, g, o);
      v = {v[5:0], g};
      all_oe &= o;
    end
  endtask

  task automatic write_reg(input logic [7:0] op, input logic [7:0] v);
    logic o;
    begin_x();
    send(op, o);
    send(v, o);
    end_x();
  endtask

  task automatic cmd_only(input logic [7:0] op);
    logic o;
    begin_x();
    send(op, o);
    end_x();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic o, any;
    logic [1:0] g;
    logic [7:0] b1, b2;
    logic [23:0] id;
    logic id_ok;
    id = {MFR, DEV};

    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R7 reset values, R3 pads off
    chk(cfg_vol == CFG_DEF, "R7 reset cfg_vol", cfg_vol, CFG_DEF);
    chk(cfg_enh == ENH_DEF, "R7 reset cfg_enh", cfg_enh, ENH_DEF);
    chk(dq_oe == 2'b00, "R3 reset oe", dq_oe, 0);

    // R1/R2 identity read, R3 enables low during command
    begin_x();
    send(ID_OP, any);
    chk(!any, "R3 oe during command", any, 0);
    for (int i = 0; i < 12; i++) begin
      pulse(2'b00, g, o);
      chk(o && g == id[23-2*i -: 2], "R2 id pair", {o, g}, {1'b1, id[23-2*i -: 2]});
    end
    pulse(2'b00, g, o);
    chk(!o, "R2 release after 12 pairs", o, 0);
    end_x();

    // R1 command bit ordering: swapped-pair opcode is not identity
    begin_x();
    send({ID_OP[6], ID_OP[7], ID_OP[4], ID_OP[5], ID_OP[2], ID_OP[3], ID_OP[0], ID_OP[1]}, any);
    pulse(2'b00, g, o);
    chk(!o, "R1 pair order matters", o, 0);
    end_x();

    // R4 busy blocks identity
    busy = 1'b1;
    begin_x();
    send(ID_OP, any);
    any = 1'b0;
    for (int i = 0; i < 12; i++) begin
      pulse(2'b00, g, o);
      any |= o;
    end
    chk(!any, "R4 id ignored while busy", any, 0);
    end_x();
    busy = 1'b0;

    // R5/R6 sweep over both registers
    for (int v = 0; v < 256; v += 3) begin
      write_reg(8'h81, 8'(v));
      chk(cfg_vol == 8'(v), "R5 cfg_vol write", cfg_vol, v);
      begin_x();
      send(8'h85, any);
      read_byte(b1, o);
      read_byte(b2, any);
      chk(o && any && b1 == 8'(v) && b2 == 8'(v), "R6 cfg_vol read repeat", {b1, b2}, {8'(v), 8'(v)});
      end_x();

      write_reg(8'h61, 8'(v) ^ 8'h5A);
      chk(cfg_enh == (8'(v) ^ 8'h5A), "R5 cfg_enh write", cfg_enh, 8'(v) ^ 8'h5A);
      begin_x();
      send(8'h65, any);
      read_byte(b1, o);
      read_byte(b2, any);
      chk(o && any && b1 == (8'(v) ^ 8'h5A) && b2 == b1, "R6 cfg_enh read repeat",
          {b1, b2}, {8'(v) ^ 8'h5A, 8'(v) ^ 8'h5A});
      end_x();
    end

    // R5 partial byte is dropped; last full byte wins
    write_reg(8'h81, 8'h12);
    begin_x();
    send(8'h81, any);
    for (int i = 0; i < 3; i++) pulse(2'b11, g, o);
    end_x();
    chk(cfg_vol == 8'h12, "R5 partial byte dropped", cfg_vol, 8'h12);
    begin_x();
    send(8'h61, any);
    send(8'h11, any);
    send(8'h22, any);
    end_x();
    chk(cfg_enh == 8'h22, "R5 last byte wins", cfg_enh, 8'h22);

    // R7 armed reset
    write_reg(8'h61, 8'h34);
    cmd_only(8'h66);
    cmd_only(8'h99);
    chk(cfg_vol == CFG_DEF && cfg_enh == ENH_DEF, "R7 armed reset",
        {cfg_vol, cfg_enh}, {CFG_DEF, ENH_DEF});

    // R8 unarmed reset
    write_reg(8'h81, 8'h12);
    write_reg(8'h61, 8'h34);
    cmd_only(8'h99);
    chk(cfg_vol == 8'h12 && cfg_enh == 8'h34, "R8 reset alone", {cfg_vol, cfg_enh}, 16'h1234);
    cmd_only(8'h66);
    begin_x();
    send(8'h85, any);
    read_byte(b1, o);
    end_x();
    cmd_only(8'h99);
    chk(cfg_vol == 8'h12 && cfg_enh == 8'h34, "R8 reset after intervening cmd",
        {cfg_vol, cfg_enh}, 16'h1234);

    // R9 unknown commands
    begin_x();
    send(8'h00, any);
    read_byte(b1, o);
    read_byte(b2, any);
    end_x();
    chk(!o && !any, "R9 oe low for 00h", {o, any}, 0);
    begin_x();
    send(8'hA5, any);
    send(8'h77, any);
    pulse(2'b00, g, o);
    end_x();
    chk(!o && cfg_vol == 8'h12 && cfg_enh == 8'h34, "R9 A5h ignored",
        {o, cfg_vol, cfg_enh}, {1'b0, 16'h1234});

    // R10 abort mid output, then a fresh identity read
    begin_x();
    send(ID_OP, any);
    for (int i = 0; i < 3; i++) pulse(2'b00, g, o);
    repeat (H) @(negedge clk);
    cs_n = 1'b1;
    repeat (6) @(negedge clk);
    chk(dq_oe == 2'b00, "R10 release on abort", dq_oe, 0);
    repeat (3*H) @(negedge clk);
    begin_x();
    send(ID_OP, any);
    id_ok = 1'b1;
    for (int i = 0; i < 12; i++) begin
      pulse(2'b00, g, o);
      if (!(o && g == id[23-2*i -: 2])) id_ok = 1'b0;
    end
    end_x();
    chk(id_ok, "R10 fresh id after abort", id_ok, 1);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule